// File: doc/BRIEF.md
# Data ALU Late-Execution Interlock Controller

This block sits beside the data ALU of a DSP core pipeline (fetch, two prefetch stages, decode, address generation, operand fetch, Execute, Execute 2). It keeps track of whether the ALU pipeline runs in Normal or Late mode. It tells the pipeline, for every accepted instruction, whether that instruction finishes in Execute or in Execute 2. It also raises a one-cycle interlock stall when an instruction waiting in operand fetch needs a result that is not yet available.

A two-stage operation (multiply, multiply-accumulate) occupies both execute stages and switches the pipeline into a sticky Late mode. Later single-stage ALU operations inherit this mode and also finish in Execute 2. Only an instruction outside the data ALU returns the pipeline to Normal. An instruction that reads a late result as a multiplier input, stores it to memory or tests the condition codes it produced is held for one cycle. An instruction that reads the result only as its accumulation input runs on without a stall.

Each cycle the decoder presents a descriptor in operand fetch: a class, two source register indices, a destination index, a multiplier-role flag for each source, a store flag and a condition-code flag. While stall is high the decoder keeps the same descriptor on the inputs.

Top module: `alu_late_interlock`

## Requirements
- R1: During and right after reset, late_mode is 0, stall_req is 0 and done_ex2 is 0.
- R2: op_class encoding: 2'b00 is a non-ALU instruction, 2'b01 is a single-stage ALU instruction, 2'b10 is a two-stage ALU instruction, and 2'b11 is treated exactly like 2'b00.
- R3: An instruction is accepted when op_valid is 1 and stall_req is 0. An accepted single-stage ALU instruction in Normal mode gives done_ex2 = 0. An accepted non-ALU instruction always gives done_ex2 = 0.
- R4: An accepted two-stage instruction gives done_ex2 = 1 in the same cycle, and late_mode is 1 in the following cycle.
- R5: An accepted single-stage ALU instruction while late_mode is 1 gives done_ex2 = 1, and late_mode stays 1.
- R6: An accepted non-ALU instruction makes late_mode 0 in the following cycle. Idle cycles (op_valid = 0) leave late_mode unchanged.
- R7: stall_req is 1 when the instruction accepted in the previous cycle was an ALU instruction with done_ex2 = 1 and the current instruction has op_mul_a = 1 with op_src_a equal to that instruction's op_dst, or op_mul_b = 1 with op_src_b equal to it.
- R8: A source index that matches such a late destination does not stall when its multiplier flag is 0 (accumulation use), unless R9 or R10 applies.
- R9: stall_req is 1 when the previous accepted instruction was an ALU instruction with done_ex2 = 1 and the current instruction has op_store = 1 with op_src_a equal to that destination.
- R10: stall_req is 1 when op_cc_use = 1 and the previous accepted instruction was an ALU instruction with done_ex2 = 1. After an ALU instruction with done_ex2 = 0, op_cc_use causes no stall.
- R11: stall_req never stays high for two cycles in a row. In a stall cycle nothing is accepted (done_ex2 = 0) and late_mode does not change.
- R12: stall_req is 0 when op_valid is 0. It is also 0 when the previous cycle was idle, a stall, or an accepted non-ALU instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An instruction descriptor is present in operand fetch |
| op_class | input | 2 | Instruction class (see R2) |
| op_src_a | input | 4 | First source register index |
| op_src_b | input | 4 | Second source register index |
| op_dst | input | 4 | Destination register index |
| op_mul_a | input | 1 | First source feeds a multiplier input |
| op_mul_b | input | 1 | Second source feeds a multiplier input |
| op_store | input | 1 | Instruction writes the register named by op_src_a to memory |
| op_cc_use | input | 1 | Instruction depends on the condition codes |
| stall_req | output | 1 | Hold decode and earlier stages for this cycle |
| done_ex2 | output | 1 | Accepted instruction completes in Execute 2 (1) or Execute (0) |
| late_mode | output | 1 | Current pipeline mode: 1 Late, 0 Normal |

## Verification
A directed sequence walks the mode through Normal, Late through a two-stage operation, inherited Late through single-stage operations, and back to Normal through a non-ALU instruction and through class 2'b11. This separates mode tracking from plain class decoding. Matching register indices are presented once with and once without the multiplier flag, which separates multiplier use from accumulation use. Store and condition-code consumers are placed after both early-finishing and late-finishing producers, and after idle gaps, to show that only a late producer issued in the cycle just before causes a stall. A long random stream with a small register index range then produces frequent matches, back-to-back stalls and held descriptors, and is compared cycle by cycle with a behavioural model.

// File: rtl/ali_pkg.sv
package ali_pkg;

  typedef enum logic [1:0] {
    CLS_NONALU = 2'b00,
    CLS_SINGLE = 2'b01,
    CLS_TWO    = 2'b10,
    CLS_RSVD   = 2'b11
  } op_class_e;

  // True for instructions executed by the data ALU.
  function automatic logic is_alu(input logic [1:0] cls);
    return (cls == CLS_SINGLE) || (cls == CLS_TWO);
  endfunction

  // True for instructions occupying both execute stages.
  function automatic logic is_two_stage(input logic [1:0] cls);
    return cls == CLS_TWO;
  endfunction

  // Completion stage of an accepted instruction: 1 = Execute 2.
  function automatic logic finish_late(input logic late, input logic [1:0] cls);
    return is_two_stage(cls) || (late && (cls == CLS_SINGLE));
  endfunction

  // Mode after accepting an instruction of class cls.
  function automatic logic mode_after(input logic late, input logic [1:0] cls);
    if (is_two_stage(cls)) return 1'b1;
    if (!is_alu(cls))      return 1'b0;
    return late;
  endfunction

endpackage

// File: rtl/ali_mode_reg.sv
module ali_mode_reg
  import ali_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] cls,
  output logic       late_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      late_q <= 1'b0;
    else if (accept) late_q <= mode_after(late_q, cls);
  end

endmodule

// File: rtl/ali_ex_record.sv
module ali_ex_record
  import ali_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       cls,
  input  logic             finish_ex2,
  input  logic [IDX_W-1:0] dst,
  output logic             rec_live,
  output logic [IDX_W-1:0] rec_dst
);

  // rec_live: the instruction now in the execute stages is an ALU op that
  // completes in Execute 2 and was accepted in the cycle just before.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_live <= 1'b0;
      rec_dst  <= '0;
    end else begin
      rec_live <= accept && is_alu(cls) && finish_ex2;
      if (accept) rec_dst <= dst;
    end
  end

endmodule

// File: rtl/ali_hazard.sv
module ali_hazard #(
  parameter int IDX_W = 4
) (
  input  logic             op_valid,
  input  logic             rec_live,
  input  logic [IDX_W-1:0] rec_dst,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic             mul_a,
  input  logic             mul_b,
  input  logic             store,
  input  logic             cc_use,
  output logic             mul_hit,
  output logic             store_hit,
  output logic             cc_hit,
  output logic             hazard
);

  logic a_match, b_match;

  always_comb begin
    a_match   = src_a == rec_dst;
    b_match   = src_b == rec_dst;
    mul_hit   = (mul_a && a_match) || (mul_b && b_match);
    store_hit = store && a_match;
    cc_hit    = cc_use;
    hazard    = op_valid && rec_live && (mul_hit || store_hit || cc_hit);
  end

endmodule

// File: rtl/alu_late_interlock.sv
module alu_late_interlock
  import ali_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_class,
  input  logic [IDX_W-1:0] op_src_a,
  input  logic [IDX_W-1:0] op_src_b,
  input  logic [IDX_W-1:0] op_dst,
  input  logic             op_mul_a,
  input  logic             op_mul_b,
  input  logic             op_store,
  input  logic             op_cc_use,
  output logic             stall_req,
  output logic             done_ex2,
  output logic             late_mode
);

  logic             accept;
  logic             late_q;
  logic             finish_ex2;
  logic             rec_live;
  logic [IDX_W-1:0] rec_dst;
  logic             mul_hit, store_hit, cc_hit, hazard;

  ali_hazard #(.IDX_W(IDX_W)) u_haz (
    .op_valid (op_valid),
    .rec_live (rec_live),
    .rec_dst  (rec_dst),
    .src_a    (op_src_a),
    .src_b    (op_src_b),
    .mul_a    (op_mul_a),
    .mul_b    (op_mul_b),
    .store    (op_store),
    .cc_use   (op_cc_use),
    .mul_hit  (mul_hit),
    .store_hit(store_hit),
    .cc_hit   (cc_hit),
    .hazard   (hazard)
  );

  assign accept     = op_valid && !hazard;
  assign finish_ex2 = finish_late(late_q, op_class);

  ali_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .cls   (op_class),
    .late_q(late_q)
  );

  ali_ex_record #(.IDX_W(IDX_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cls       (op_class),
    .finish_ex2(finish_ex2),
    .dst       (op_dst),
    .rec_live  (rec_live),
    .rec_dst   (rec_dst)
  );

  assign stall_req = hazard;
  assign done_ex2  = accept && finish_ex2;
  assign late_mode = late_q;

endmodule

// File: rtl/alu_late_interlock_chk.sv
module alu_late_interlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_class,
  input logic       accept,
  input logic       stall_req,
  input logic       done_ex2,
  input logic       late_mode
);

  logic single_op, two_op, other_op;
  assign single_op = op_class == 2'b01;
  assign two_op    = op_class == 2'b10;
  assign other_op  = !single_op && !two_op;

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> !stall_req); // R11
  AST_STALL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> $stable(late_mode)); // R11
  AST_STALL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> !done_ex2); // R11
  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> op_valid); // R12
  AST_TWO_SETS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && two_op) |=> late_mode); // R4
  AST_TWO_DONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && two_op) |-> done_ex2); // R4
  AST_NORMAL_SINGLE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && single_op && !late_mode) |-> !done_ex2); // R3
  AST_LATE_SINGLE_INHERITS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && single_op && late_mode) |=> late_mode); // R5
  AST_OTHER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && other_op) |=> !late_mode); // R6
  AST_IDLE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(late_mode)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!late_mode && !stall_req)); // R1

endmodule

bind alu_late_interlock alu_late_interlock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_class (op_class),
  .accept   (accept),
  .stall_req(stall_req),
  .done_ex2 (done_ex2),
  .late_mode(late_mode)
);

// File: tb/alu_late_interlock_tb.sv
module alu_late_interlock_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [3:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic       op_mul_a = 1'b0, op_mul_b = 1'b0, op_store = 1'b0, op_cc_use = 1'b0;
  logic       stall_req, done_ex2, late_mode;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_late = 0;
  int m_prev_late_alu = 0;
  int m_prev_dst = 0;

  int g_stall, g_done;

  always #2 clk = ~clk;

  alu_late_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
    .op_mul_a(op_mul_a), .op_mul_b(op_mul_b), .op_store(op_store),
    .op_cc_use(op_cc_use), .stall_req(stall_req), .done_ex2(done_ex2),
    .late_mode(late_mode)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare against the model, advance the model at posedge.
  task automatic cyc(input int v, input int cls, input int sa, input int sb, input int d,
                     input int ma, input int mb, input int st, input int cc);
    int e_stall, e_acc, e_alu, e_done;
    op_valid = v[0]; op_class = cls[1:0]; op_src_a = sa[3:0]; op_src_b = sb[3:0];
    op_dst = d[3:0]; op_mul_a = ma[0]; op_mul_b = mb[0]; op_store = st[0]; op_cc_use = cc[0];
    #1;
    e_stall = (v != 0 && m_prev_late_alu != 0 &&
               ((ma != 0 && sa == m_prev_dst) || (mb != 0 && sb == m_prev_dst) ||
                (st != 0 && sa == m_prev_dst) || cc != 0)) ? 1 : 0;
    e_acc  = (v != 0 && e_stall == 0) ? 1 : 0;
    e_alu  = (cls == 1 || cls == 2) ? 1 : 0;
    e_done = (e_acc != 0 && (cls == 2 || (cls == 1 && m_late != 0))) ? 1 : 0;
    g_stall = int'(stall_req);
    g_done  = int'(done_ex2);
    chk("R7/R9/R10/R12 stall_req", g_stall, e_stall);
    chk("R3/R4/R5 done_ex2", g_done, e_done);
    chk("R4/R6 late_mode", int'(late_mode), m_late);
    @(posedge clk);
    if (e_acc != 0) begin
      if (cls == 2) m_late = 1;
      else if (e_alu == 0) m_late = 0;
      m_prev_dst = d;
    end
    m_prev_late_alu = (e_acc != 0 && e_alu != 0 && e_done != 0) ? 1 : 0;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 late_mode in reset", int'(late_mode), 0);
    chk("R1 stall_req in reset", int'(stall_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 late_mode after reset", int'(late_mode), 0);
    chk("R1 done_ex2 after reset", int'(done_ex2), 0);

    // R3: single-stage in Normal
    cyc(1, 1, 2, 3, 1, 0, 0, 0, 0); chk("R3 normal single done", g_done, 0);
    // R10: cc consumer after early producer: no stall
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1); chk("R10 cc after early no stall", g_stall, 0);
    // R4: two-stage
    cyc(1, 2, 5, 6, 4, 1, 1, 0, 0); chk("R4 two-stage done", g_done, 1);
    chk("R4 late after two-stage", int'(late_mode), 1);
    // R5 + R8: single reads r4 as accumulation only
    cyc(1, 1, 4, 4, 7, 0, 0, 0, 0); chk("R8 accumulate no stall", g_stall, 0);
    chk("R5 inherited late done", g_done, 1);
    chk("R5 late kept", int'(late_mode), 1);
    // R8: mac with r7 on accumulate, other source on multiplier
    cyc(1, 2, 7, 8, 9, 0, 1, 0, 0); chk("R8 mac accumulate no stall", g_stall, 0);
    // R7: multiplier source b matches r9
    cyc(1, 2, 3, 9, 10, 1, 1, 0, 0); chk("R7 mul dependency stall", g_stall, 1);
    chk("R11 no done during stall", g_done, 0);
    cyc(1, 2, 3, 9, 10, 1, 1, 0, 0); chk("R11 stall one cycle", g_stall, 0);
    chk("R11 held op accepted late", g_done, 1);
    // R9: store of r10
    cyc(1, 0, 10, 0, 0, 0, 0, 1, 0); chk("R9 store stall", g_stall, 1);
    cyc(1, 0, 10, 0, 0, 0, 0, 1, 0); chk("R9 store then accepted", g_stall, 0);
    chk("R3 non-ALU done", g_done, 0);
    chk("R6 late cleared by non-ALU", int'(late_mode), 0);
    // R12: idle gap hides a late producer
    cyc(1, 2, 1, 1, 11, 1, 1, 0, 0);
    idle();
    chk("R6 idle keeps late", int'(late_mode), 1);
    cyc(1, 1, 11, 0, 12, 0, 0, 1, 1); chk("R12 after idle no stall", g_stall, 0);
    // R10: cc after late single
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1); chk("R10 cc after late stall", g_stall, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1); chk("R12 after stall no stall", g_stall, 0);
    // R2: class 3 acts as non-ALU
    cyc(1, 2, 1, 1, 5, 1, 1, 0, 0);
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0); chk("R2 class 3 done", g_done, 0);
    chk("R2 class 3 clears late", int'(late_mode), 0);
    cyc(1, 0, 5, 5, 0, 1, 1, 1, 1); chk("R12 after non-ALU no stall", g_stall, 0);
    cyc(0, 2, 5, 5, 5, 1, 1, 1, 1); chk("R12 invalid no stall", g_stall, 0);

    // random stream with a narrow register range
    for (int i = 0; i < 3000; i++) begin
      int v, cls, sa, sb, d, ma, mb, st, cc;
      v = ($urandom_range(0, 7) != 0) ? 1 : 0;
      cls = $urandom_range(0, 3);
      sa = $urandom_range(0, 3); sb = $urandom_range(0, 3); d = $urandom_range(0, 3);
      ma = $urandom_range(0, 1); mb = $urandom_range(0, 1);
      st = ($urandom_range(0, 3) == 0) ? 1 : 0;
      cc = ($urandom_range(0, 4) == 0) ? 1 : 0;
      cyc(v, cls, sa, sb, d, ma, mb, st, cc);
      if (g_stall != 0) cyc(v, cls, sa, sb, d, ma, mb, st, cc);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule